// File: doc/BRIEF.md
# Trusted Memory Access Gate

This block sits between a command-executing engine and its memory port and decides, access by access, whether data passes through a cipher stage. Each request arrives with the 64-bit page table entry that maps it. The gate checks the entry for validity and for the read or write permission the access needs. It forms the physical address from the page base and the in-page offset. It also holds a transaction trust flag that the command stream raises and lowers at command-buffer boundaries.

Writes and reads are treated differently. A write is encrypted whenever the trust flag or the page's protection bit is set. A read is decrypted only when both are set. A request tagged as coming from the host-processor domain is never decrypted. A wrongly set protection bit can therefore never hand plaintext to an untrusted party.

In display mode, a single register bit stands in for the page's protection bit. The cipher is a reversible placeholder: the data is XORed with a keystream built from a programmable key and the physical page number. One request is outstanding at a time.

Top module: `tmg_gate`

## Requirements
- R1: A write that passes the permission check carries data XOR keystream to memory when the trust flag is 1 or the effective protection bit is 1, and carries the plain data only when both are 0; the host tag has no effect on writes.
- R2: Read data is returned as memory data XOR keystream only when the trust flag is 1, the effective protection bit is 1 and the host tag is 0; every other combination returns the memory data unchanged.
- R3: A read with the host tag at 1 returns the memory data unchanged for every value of the trust flag and the protection bit.
- R4: The trust flag is 0 after reset, is set by a trust_enter pulse and cleared by a trust_exit pulse. It holds when neither pulse is present, and trust_exit wins when both arrive in the same cycle.
- R5: A request accepted in the same cycle as a trust pulse uses the trust flag from before that pulse; the new value applies to requests accepted in later cycles.
- R6: With disp_mode at 1, the effective protection bit equals disp_secure and PTE bit 3 is ignored; with disp_mode at 0 it equals PTE bit 3.
- R7: PTE layout, LSB first: bit 0 valid, bit 1 system, bit 2 cacheable, bit 3 protection, bit 4 execute, bit 5 read, bit 6 write, bits 11:7 fragment, bits 47:12 page number. An accepted request with bit 0 at 0, or a write with bit 6 at 0, or a read with bit 5 at 0, raises fault for exactly the one cycle after acceptance and issues no memory request.
- R8: The memory address is {PTE[47:12], req_off}. The keystream bit b equals key[b] XOR the XOR of page-number bits j for every j with j mod DW == b, so equal data on different pages or under different keys encrypts differently.
- R9: req_ready is 1 only while no request is in flight. The memory request stays valid with stable address, data and direction until mem_req_ready is seen.
- R10: rd_valid pulses in the cycle after mem_rsp_valid is seen for a pending read, with the decrypt decision and keystream taken in the request's acceptance cycle; trust changes after acceptance do not alter it.
- R11: After reset req_ready is 1 and mem_req_valid, rd_valid and fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Engine request valid |
| req_ready | output | 1 | Gate can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 12 | Byte offset within the 4 KB page |
| req_wdata | input | DW | Write data (plaintext) |
| req_pte | input | 64 | Page table entry for this access |
| req_host | input | 1 | Request comes from the untrusted host domain |
| trust_enter | input | 1 | Secure command buffer starts |
| trust_exit | input | 1 | Non-secure command buffer starts |
| disp_mode | input | 1 | Protection decision taken from disp_secure |
| disp_secure | input | 1 | Display-mode protection bit |
| key | input | DW | Cipher key |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Memory request direction |
| mem_req_addr | output | 48 | Physical byte address |
| mem_req_wdata | output | DW | Data written to memory |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | DW | Read response data |
| rd_valid | output | 1 | Returned read data valid |
| rd_data | output | DW | Returned read data |
| fault | output | 1 | Access blocked by PTE check |

## Verification
The bench builds the gate with DW = 32 and the address-bound keystream variant. A 36-bit page number then folds into the keystream with four bits wrapping onto the low positions, which makes the wrap arithmetic observable. The small configuration lets the bench sweep all four write cases of trust and protection and all eight read cases of trust, protection and host tag against the same stored word. It computes each expected word from its own keystream formula. Display-mode, same-cycle trust pulse, memory stall and permission-fault cases are run on top of the sweep.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
   localparam int PTE_W     = 64;
   localparam int PG_SHIFT  = 12;
   localparam int PG_NUM_W  = 36;
   localparam int PA_W      = PG_SHIFT + PG_NUM_W;

   typedef struct packed {
      logic [15:0]         rsvd;
      logic [PG_NUM_W-1:0] page;
      logic [4:0]          frag;
      logic                can_wr;
      logic                can_rd;
      logic                can_ex;
      logic                protect;
      logic                cacheable;
      logic                sysmem;
      logic                valid;
   } pte_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } gate_st_e;
endpackage

// File: rtl/tmg_pte_decode.sv
module tmg_pte_decode
   import tmg_pkg::*;
(
   input  logic [PTE_W-1:0]    pte,
   input  logic                is_write,
   input  logic                disp_mode,
   input  logic                disp_secure,
   output logic [PG_NUM_W-1:0] page,
   output logic                prot_eff,
   output logic                perm_ok
);
   pte_t f;
   logic unused_pte_bits;

   assign f        = pte_t'(pte);
   assign page     = f.page;
   assign prot_eff = disp_mode ? disp_secure : f.protect;
   assign perm_ok  = f.valid & (is_write ? f.can_wr : f.can_rd);
   assign unused_pte_bits = ^{f.rsvd, f.frag, f.can_ex, f.cacheable, f.sysmem};
endmodule

// File: rtl/tmg_trust_reg.sv
module tmg_trust_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic leave,
   output logic trust_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     trust_q <= 1'b0;
      else if (leave) trust_q <= 1'b0;
      else if (enter) trust_q <= 1'b1;
   end
endmodule

// File: rtl/tmg_keystream.sv
module tmg_keystream
   import tmg_pkg::*;
#(
   parameter int DW        = 32,
   parameter bit ADDR_BIND = 1'b1
) (
   input  logic [DW-1:0]       key,
   input  logic [PG_NUM_W-1:0] page,
   output logic [DW-1:0]       ks
);
   generate
      if (ADDR_BIND) begin : g_bound
         logic [DW-1:0] fold;
         always_comb begin
            fold = '0;
            for (int i = 0; i < PG_NUM_W; i++)
               fold[i % DW] = fold[i % DW] ^ page[i];
         end
         assign ks = key ^ fold;
      end else begin : g_keyonly
         logic unused_page;
         assign unused_page = ^page;
         assign ks = key;
      end
   endgenerate
endmodule

// File: rtl/tmg_gate.sv
module tmg_gate
   import tmg_pkg::*;
#(
   parameter int DW        = 32,
   parameter bit ADDR_BIND = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [PG_SHIFT-1:0] req_off,
   input  logic [DW-1:0]       req_wdata,
   input  logic [PTE_W-1:0]    req_pte,
   input  logic                req_host,
   input  logic                trust_enter,
   input  logic                trust_exit,
   input  logic                disp_mode,
   input  logic                disp_secure,
   input  logic [DW-1:0]       key,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic                mem_req_write,
   output logic [PA_W-1:0]     mem_req_addr,
   output logic [DW-1:0]       mem_req_wdata,
   input  logic                mem_rsp_valid,
   input  logic [DW-1:0]       mem_rsp_rdata,
   output logic                rd_valid,
   output logic [DW-1:0]       rd_data,
   output logic                fault
);
   generate
      if (DW < 8 || DW > 64) begin : g_bad_dw
         $error("tmg_gate: DW must lie in 8..64");
      end
   endgenerate

   gate_st_e            state_q;
   logic                trust_q;
   logic [PG_NUM_W-1:0] page;
   logic                prot_eff, perm_ok;
   logic [DW-1:0]       ks;
   logic                accept, do_enc, do_dec;
   logic                pend_dec_q;
   logic [DW-1:0]       pend_ks_q;
   logic                fault_q, rd_valid_q;
   logic [DW-1:0]       rd_data_q;
   logic                wr_q;
   logic [PA_W-1:0]     addr_q;
   logic [DW-1:0]       wdata_q;

   tmg_pte_decode u_dec (
      .pte(req_pte), .is_write(req_write), .disp_mode(disp_mode),
      .disp_secure(disp_secure), .page(page), .prot_eff(prot_eff), .perm_ok(perm_ok)
   );

   tmg_trust_reg u_trust (
      .clk(clk), .rst_n(rst_n), .enter(trust_enter), .leave(trust_exit), .trust_q(trust_q)
   );

   tmg_keystream #(.DW(DW), .ADDR_BIND(ADDR_BIND)) u_ks (
      .key(key), .page(page), .ks(ks)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid & req_ready;
   assign do_enc    = trust_q | prot_eff;
   assign do_dec    = trust_q & prot_eff & ~req_host;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         fault_q    <= 1'b0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
         pend_dec_q <= 1'b0;
         pend_ks_q  <= '0;
         wr_q       <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
      end else begin
         fault_q    <= 1'b0;
         rd_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (!perm_ok) begin
                     fault_q <= 1'b1;
                  end else begin
                     wr_q       <= req_write;
                     addr_q     <= {page, req_off};
                     wdata_q    <= req_wdata ^ (do_enc ? ks : '0);
                     pend_dec_q <= do_dec;
                     pend_ks_q  <= ks;
                     state_q    <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready)
                  state_q <= wr_q ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  rd_valid_q <= 1'b1;
                  rd_data_q  <= mem_rsp_rdata ^ (pend_dec_q ? pend_ks_q : '0);
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state_q == ST_ISSUE);
   assign mem_req_write = wr_q;
   assign mem_req_addr  = addr_q;
   assign mem_req_wdata = wdata_q;
   assign rd_valid      = rd_valid_q;
   assign rd_data       = rd_data_q;
   assign fault         = fault_q;
endmodule

// File: rtl/tmg_gate_chk.sv
module tmg_gate_chk
   import tmg_pkg::*;
#(
   parameter int DW = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic            mem_req_write,
   input logic [PA_W-1:0] mem_req_addr,
   input logic [DW-1:0]   mem_req_wdata,
   input logic            mem_rsp_valid,
   input logic            rd_valid,
   input logic            fault,
   input logic            trust_enter,
   input logic            trust_exit,
   input logic            trust_q
);
   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_wdata) && $stable(mem_req_write));
   // R9
   rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready && !mem_req_write |=> !req_ready);
   // R7
   fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(req_valid && req_ready) && !mem_req_valid);
   // R7
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault || $past(req_valid && req_ready));
   // R4
   trust_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trust_exit |=> !trust_q);
   // R4
   trust_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trust_enter && !trust_exit |=> trust_q);
   // R4
   trust_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trust_enter && !trust_exit |=> $stable(trust_q));
   // R10
   rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(mem_rsp_valid));
endmodule

bind tmg_gate tmg_gate_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
   .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
   .rd_valid(rd_valid), .fault(fault), .trust_enter(trust_enter),
   .trust_exit(trust_exit), .trust_q(trust_q)
);

// File: tb/tmg_gate_bench.sv
module tmg_gate_bench;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_host = 1'b0;
   logic [11:0]   req_off = '0;
   logic [DW-1:0] req_wdata = '0, key = 32'h5A3C_96E1;
   logic [63:0]   req_pte = '0;
   logic          trust_enter = 1'b0, trust_exit = 1'b0;
   logic          disp_mode = 1'b0, disp_secure = 1'b0;
   logic          mem_req_ready = 1'b1;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rsp_rdata = '0;
   logic          req_ready, mem_req_valid, mem_req_write, rd_valid, fault;
   logic [47:0]   mem_req_addr;
   logic [DW-1:0] mem_req_wdata, rd_data;

   int checks = 0, failures = 0;
   int mem_ops = 0;
   logic [DW-1:0] mem [0:255];
   logic [47:0]   last_addr = '0;

   always #5 clk = ~clk;

   tmg_gate #(.DW(DW), .ADDR_BIND(1'b1)) u_tmg_gate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_off(req_off), .req_wdata(req_wdata),
      .req_pte(req_pte), .req_host(req_host), .trust_enter(trust_enter),
      .trust_exit(trust_exit), .disp_mode(disp_mode), .disp_secure(disp_secure),
      .key(key), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .fault(fault)
   );

   function automatic logic [7:0] idx_of(input logic [47:0] a);
      return {a[14:12], a[6:2]};
   endfunction

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         mem_ops   <= mem_ops + 1;
         last_addr <= mem_req_addr;
         if (mem_req_write) mem[idx_of(mem_req_addr)] <= mem_req_wdata;
         else begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_rdata <= mem[idx_of(mem_req_addr)];
         end
      end
   end

   function automatic logic [DW-1:0] ks_of(input logic [DW-1:0] k, input logic [35:0] pg);
      logic [DW-1:0] r;
      for (int b = 0; b < DW; b++) begin
         r[b] = k[b];
         for (int j = b; j < 36; j += DW) r[b] = r[b] ^ pg[j];
      end
      return r;
   endfunction

   function automatic logic [63:0] mk_pte(input logic [35:0] pg, input logic prot,
                                          input logic rd, input logic wr, input logic vld);
      return {16'h0, pg, 5'h03, wr, rd, 1'b0, prot, 1'b1, 1'b0, vld};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic wr, input logic [63:0] pte, input logic [11:0] off,
                         input logic [DW-1:0] d, input logic host, input logic ten,
                         input logic tex, output logic [DW-1:0] rdat);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_pte = pte; req_off = off;
      req_wdata = d; req_host = host; trust_enter = ten; trust_exit = tex;
      @(negedge clk);
      req_valid = 1'b0; trust_enter = 1'b0; trust_exit = 1'b0;
      while (!req_ready) @(negedge clk);
      rdat = rd_data;
   endtask

   task automatic set_trust(input logic v);
      @(negedge clk);
      trust_enter = v; trust_exit = ~v;
      @(negedge clk);
      trust_enter = 1'b0; trust_exit = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [DW-1:0] got, stored, pt, ks;
      logic [35:0]   pg;
      int            ops0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11", {req_ready, mem_req_valid, rd_valid, fault}, 4'b1000);

      // R4: trust is 0 after reset -> unprotected write stays plain
      pg = 36'h0_0000_1000;
      do_req(1'b1, mk_pte(pg, 1'b0, 1'b1, 1'b1, 1'b1), 12'h020, 32'h1234_5678, 1'b0, 1'b0, 1'b0, got);
      check("R4", mem[idx_of({pg, 12'h020})], 32'h1234_5678);
      // R8 address
      check("R8", last_addr, {pg, 12'h020});

      // R1/R2/R3 sweep
      for (int w = 0; w < 4; w++) begin
         pg = 36'h9_8765_4320 | 36'(w);
         pt = 32'hDEAD_BEEF ^ (32'h0101_1111 * w);
         ks = ks_of(key, pg);
         set_trust(w[1]);
         do_req(1'b1, mk_pte(pg, w[0], 1'b1, 1'b1, 1'b1), 12'h040, pt, 1'b0, 1'b0, 1'b0, got);
         stored = (w[1] | w[0]) ? (pt ^ ks) : pt;
         check("R1", mem[idx_of({pg, 12'h040})], stored);
         for (int r = 0; r < 8; r++) begin
            set_trust(r[2]);
            do_req(1'b0, mk_pte(pg, r[1], 1'b1, 1'b1, 1'b1), 12'h040, '0, r[0], 1'b0, 1'b0, got);
            if (r[0]) check("R3", got, stored);
            else      check("R2", got, (r[2] & r[1]) ? (stored ^ ks) : stored);
         end
      end

      // R1: host tag does not change write encryption
      set_trust(1'b0);
      pg = 36'h0_0000_2000;
      do_req(1'b1, mk_pte(pg, 1'b1, 1'b1, 1'b1, 1'b1), 12'h044, 32'hCAFE_0001, 1'b1, 1'b0, 1'b0, got);
      check("R1", mem[idx_of({pg, 12'h044})], 32'hCAFE_0001 ^ ks_of(key, pg));

      // R8: different key gives a different ciphertext
      key = 32'h0F0F_7777;
      do_req(1'b1, mk_pte(pg, 1'b1, 1'b1, 1'b1, 1'b1), 12'h048, 32'hCAFE_0001, 1'b0, 1'b0, 1'b0, got);
      check("R8", mem[idx_of({pg, 12'h048})], 32'hCAFE_0001 ^ ks_of(32'h0F0F_7777, pg));

      // R4: enter and exit together -> not trusted
      set_trust(1'b1);
      @(negedge clk); trust_enter = 1'b1; trust_exit = 1'b1;
      @(negedge clk); trust_enter = 1'b0; trust_exit = 1'b0;
      pg = 36'h0_0000_3000;
      do_req(1'b1, mk_pte(pg, 1'b0, 1'b1, 1'b1, 1'b1), 12'h050, 32'h0BAD_F00D, 1'b0, 1'b0, 1'b0, got);
      check("R4", mem[idx_of({pg, 12'h050})], 32'h0BAD_F00D);

      // R5: strobe in the acceptance cycle uses the old state
      do_req(1'b1, mk_pte(pg, 1'b0, 1'b1, 1'b1, 1'b1), 12'h054, 32'h5555_AAAA, 1'b0, 1'b1, 1'b0, got);
      check("R5", mem[idx_of({pg, 12'h054})], 32'h5555_AAAA);
      do_req(1'b1, mk_pte(pg, 1'b0, 1'b1, 1'b1, 1'b1), 12'h058, 32'h5555_AAAA, 1'b0, 1'b0, 1'b0, got);
      check("R5", mem[idx_of({pg, 12'h058})], 32'h5555_AAAA ^ ks_of(key, pg));

      // R6: display mode
      set_trust(1'b0);
      disp_mode = 1'b1; disp_secure = 1'b1;
      pg = 36'h0_0000_4000;
      do_req(1'b1, mk_pte(pg, 1'b0, 1'b1, 1'b1, 1'b1), 12'h060, 32'h7777_0000, 1'b0, 1'b0, 1'b0, got);
      check("R6", mem[idx_of({pg, 12'h060})], 32'h7777_0000 ^ ks_of(key, pg));
      disp_secure = 1'b0;
      do_req(1'b1, mk_pte(pg, 1'b1, 1'b1, 1'b1, 1'b1), 12'h064, 32'h7777_0001, 1'b0, 1'b0, 1'b0, got);
      check("R6", mem[idx_of({pg, 12'h064})], 32'h7777_0001);
      set_trust(1'b1);
      disp_secure = 1'b1;
      do_req(1'b0, mk_pte(pg, 1'b0, 1'b1, 1'b1, 1'b1), 12'h060, '0, 1'b0, 1'b0, 1'b0, got);
      check("R6", got, 32'h7777_0000);
      disp_secure = 1'b0;
      do_req(1'b0, mk_pte(pg, 1'b1, 1'b1, 1'b1, 1'b1), 12'h060, '0, 1'b0, 1'b0, 1'b0, got);
      check("R6", got, 32'h7777_0000 ^ ks_of(key, pg));
      disp_mode = 1'b0;

      // R10: trust dropped after acceptance does not change decrypt
      do_req(1'b0, mk_pte(pg, 1'b1, 1'b1, 1'b1, 1'b1), 12'h060, '0, 1'b0, 1'b0, 1'b1, got);
      check("R10", got, 32'h7777_0000);

      // R7 faults
      ops0 = mem_ops;
      do_req(1'b1, mk_pte(pg, 1'b0, 1'b1, 1'b1, 1'b0), 12'h070, 32'h1, 1'b0, 1'b0, 1'b0, got);
      check("R7", fault, 1'b1);
      @(negedge clk);
      check("R7", fault, 1'b0);
      do_req(1'b1, mk_pte(pg, 1'b0, 1'b1, 1'b0, 1'b1), 12'h070, 32'h1, 1'b0, 1'b0, 1'b0, got);
      check("R7", fault, 1'b1);
      do_req(1'b0, mk_pte(pg, 1'b0, 1'b0, 1'b1, 1'b1), 12'h070, 32'h1, 1'b0, 1'b0, 1'b0, got);
      check("R7", fault, 1'b1);
      repeat (2) @(negedge clk);
      check("R7", mem_ops, ops0);

      // R9 stall: request held until memory is ready
      mem_req_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_pte = mk_pte(pg, 1'b0, 1'b1, 1'b1, 1'b1);
      req_off = 12'h07C; req_wdata = 32'h9999_0000; req_host = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R9", {req_ready, mem_req_valid}, 2'b01);
      check("R9", mem_req_addr, {pg, 12'h07C});
      mem_req_ready = 1'b1;
      @(negedge clk);
      check("R9", req_ready, 1'b1);
      check("R9", mem[idx_of({pg, 12'h07C})], 32'h9999_0000);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule